// File: doc/BRIEF.md
# Frequency-Modulated PWM Gate Generator with Dead Time

This block produces the two gate commands for one leg of a half-bridge inverter. A phase accumulator adds a frequency tuning word to itself on every reference clock. Each rising edge of its most significant bit is one tick, and a short duty counter advances on each tick. The PWM level comes from comparing that counter with a duty word. A small state machine splits the PWM level into a high-side command and a complementary low-side command. At every PWM edge it holds both commands low for a programmable number of reference cycles.

A host writes the words over a three-wire serial port made of a data line, a serial clock and a load strobe. A load moves the new word into a shadow register. The shadow register reaches the active register only at the end of a full PWM period, so the frequency can be swept on the fly with no truncated pulses. When the accumulator is stopped there is no period boundary, so a load takes effect at once.

The dead-time state machine has four states. OFF drives both outputs low. HIGH drives the high side. LOW drives the low side. GAP drives both low while a gap counter runs. Its transitions are:
- start: OFF to GAP, or to HIGH/LOW directly when the dead time is zero.
- fall: HIGH to GAP or LOW.
- rise: LOW to GAP or HIGH.
- expire: GAP to whichever side the PWM level selects when the gap counter reaches zero.
- stop: any state to OFF when the tuning word is zero.

Top module: `fmpwm_gen`

## Requirements
- R1: The duty counter advances once per rising edge of accumulator bit 15. With tuning word F, a power of two, a tick occurs every 65536/F reference cycles and a PWM period lasts 16 ticks.
- R2: For a duty word d in 1..14 and dead time D, each high-side pulse lasts d*T - D cycles and each low-side pulse lasts (16-d)*T - D cycles, where T is the tick spacing in cycles.
- R3: A duty word of 0 keeps the high side low and the low side high while running.
- R4: A duty word of 15 keeps the high side high and the low side low while running (100 %).
- R5: After every PWM edge both outputs are low for exactly D reference cycles before the other side turns on. D = 0 switches directly.
- R6: The high-side and low-side outputs are never high in the same cycle.
- R7: While the active tuning word is 0, both outputs are low. Words loaded in this state take effect immediately.
- R8: A serial frame is 17 bits, sent MSB first and sampled on rising edges of the serial clock. The first bit is the address: 0 selects the 16-bit tuning word. 1 selects the control word, whose bits 3:0 hold the duty and bits 15:4 hold the dead time D.
- R9: A shifted frame changes nothing until the load strobe rises. Frames shifted without a load have no effect on the outputs.
- R10: While running, a loaded word becomes active only at a PWM period boundary, the tick on which the counter wraps from 15 to 0. The pulse in progress is never altered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock, data sampled on its rising edge |
| ser_data | input | 1 | Serial data, MSB first |
| ser_load | input | 1 | Load strobe, rising edge commits the shifted frame |
| gate_hi | output | 1 | High-side (phase) gate command |
| gate_lo | output | 1 | Low-side (counter-phase) gate command |

## Verification
The serial lines are taken as synchronous to the reference clock and slow compared with it. The assertions assume that each level of the serial clock, data and strobe is held for at least two reference cycles, and that a strobe follows only a complete 17-bit frame. The bench meets this by changing these lines only on falling clock edges and holding each level for two cycles. It also keeps the dead time well below the shortest PWM phase, so that the pulse-width relations of R2 and R5 stay meaningful for every setting used.

// File: rtl/fmpwm_pkg.sv
package fmpwm_pkg;

    typedef enum logic [1:0] {
        DT_OFF  = 2'd0,
        DT_HIGH = 2'd1,
        DT_LOW  = 2'd2,
        DT_GAP  = 2'd3
    } dt_state_t;

    typedef enum logic {
        REG_FREQ = 1'b0,
        REG_CTRL = 1'b1
    } reg_sel_t;

endpackage

// File: rtl/fmpwm_serial.sv
module fmpwm_serial #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_load,
    output logic              wr_valid,
    output logic              wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    localparam int SH_W = DATA_W + 1;

    logic            sclk_q;
    logic            load_q;
    logic [SH_W-1:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q   <= 1'b0;
            load_q   <= 1'b0;
            shreg    <= '0;
            wr_valid <= 1'b0;
            wr_addr  <= 1'b0;
            wr_data  <= '0;
        end else begin
            sclk_q   <= ser_clk;
            load_q   <= ser_load;
            if (ser_clk && !sclk_q) begin
                shreg <= {shreg[SH_W-2:0], ser_data};
            end
            wr_valid <= ser_load && !load_q;
            if (ser_load && !load_q) begin
                wr_addr <= shreg[SH_W-1];
                wr_data <= shreg[DATA_W-1:0];
            end
        end
    end

    // R9: one strobe edge gives a single write pulse
    assert_single_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

endmodule

// File: rtl/fmpwm_core.sv
module fmpwm_core #(
    parameter int ACC_W = 16,
    parameter int CNT_W = 4,
    parameter int DT_W  = ACC_W - CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic             wr_addr,
    input  logic [ACC_W-1:0] wr_data,
    output logic             pwm,
    output logic             run,
    output logic [DT_W-1:0]  dead
);
    import fmpwm_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [ACC_W-1:0] ftw_sh, ftw_act;
    logic             ftw_pend;
    logic [CNT_W-1:0] duty_sh, duty_act;
    logic [DT_W-1:0]  dead_sh, dead_act;
    logic             ctrl_pend;
    logic [ACC_W-1:0] acc;
    logic             msb_q;
    logic [CNT_W-1:0] cnt;
    logic             pwm_q;
    logic             tick;
    logic             boundary;
    logic             apply;

    assign run      = (ftw_act != '0);
    assign tick     = acc[ACC_W-1] && !msb_q;
    assign boundary = tick && (cnt == CNT_MAX);
    assign apply    = boundary || !run;
    assign pwm      = pwm_q;
    assign dead     = dead_act;

    // shadow and active registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ftw_sh    <= '0;
            ftw_act   <= '0;
            ftw_pend  <= 1'b0;
            duty_sh   <= '0;
            duty_act  <= '0;
            dead_sh   <= '0;
            dead_act  <= '0;
            ctrl_pend <= 1'b0;
        end else begin
            if (apply && ftw_pend) begin
                ftw_act  <= ftw_sh;
                ftw_pend <= 1'b0;
            end
            if (apply && ctrl_pend) begin
                duty_act  <= duty_sh;
                dead_act  <= dead_sh;
                ctrl_pend <= 1'b0;
            end
            if (wr_valid && (wr_addr == REG_FREQ)) begin
                ftw_sh   <= wr_data;
                ftw_pend <= 1'b1;
            end
            if (wr_valid && (wr_addr == REG_CTRL)) begin
                duty_sh   <= wr_data[CNT_W-1:0];
                dead_sh   <= wr_data[ACC_W-1:CNT_W];
                ctrl_pend <= 1'b1;
            end
        end
    end

    // accumulator, duty counter and compare
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc   <= '0;
            msb_q <= 1'b0;
            cnt   <= '0;
            pwm_q <= 1'b0;
        end else begin
            acc   <= acc + ftw_act;
            msb_q <= acc[ACC_W-1];
            if (!run) begin
                cnt <= '0;
            end else if (tick) begin
                cnt <= cnt + 1'b1;
            end
            if (!run) begin
                pwm_q <= 1'b0;
            end else if (duty_act == CNT_MAX) begin
                pwm_q <= 1'b1;
            end else begin
                pwm_q <= (duty_act > cnt);
            end
        end
    end

    // R10: active words hold between period boundaries
    assert_boundary_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !boundary) |=> ($stable(duty_act) && $stable(ftw_act) && $stable(dead_act)));

    // R3: zero duty keeps the PWM level low
    assert_zero_duty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_act == '0) |=> !pwm);

    // R4: full duty keeps the PWM level high while running
    assert_full_duty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && duty_act == CNT_MAX) |=> pwm);

    // R7: a stopped accumulator gives a low PWM level
    assert_stopped_pwm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !pwm);

endmodule

// File: rtl/fmpwm_deadtime.sv
module fmpwm_deadtime #(
    parameter int DT_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwm,
    input  logic            run,
    input  logic [DT_W-1:0] dead,
    output logic            gate_hi,
    output logic            gate_lo
);
    import fmpwm_pkg::*;

    dt_state_t       state, nxt;
    logic [DT_W-1:0] gap_cnt;
    logic            no_gap;

    assign no_gap = (dead == '0);

    always_comb begin
        nxt = state;
        unique case (state)
            DT_OFF: begin
                if (run) begin
                    if (no_gap) nxt = pwm ? DT_HIGH : DT_LOW;
                    else        nxt = DT_GAP;
                end
            end
            DT_HIGH: begin
                if (!run)      nxt = DT_OFF;
                else if (!pwm) nxt = no_gap ? DT_LOW : DT_GAP;
            end
            DT_LOW: begin
                if (!run)      nxt = DT_OFF;
                else if (pwm)  nxt = no_gap ? DT_HIGH : DT_GAP;
            end
            DT_GAP: begin
                if (!run)                 nxt = DT_OFF;
                else if (gap_cnt == '0)   nxt = pwm ? DT_HIGH : DT_LOW;
            end
            default: nxt = DT_OFF;
        endcase
    end

    // state register and gap counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= DT_OFF;
            gap_cnt <= '0;
        end else begin
            state <= nxt;
            if (nxt == DT_GAP && state != DT_GAP) begin
                gap_cnt <= dead - 1'b1;
            end else if (state == DT_GAP && gap_cnt != '0) begin
                gap_cnt <= gap_cnt - 1'b1;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_hi <= 1'b0;
            gate_lo <= 1'b0;
        end else begin
            gate_hi <= (nxt == DT_HIGH);
            gate_lo <= (nxt == DT_LOW);
        end
    end

    // R6: no shoot-through
    assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi && gate_lo));

    // R7: stop forces both sides low
    assert_stop_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!gate_hi && !gate_lo));

    // R5: with a nonzero gap the high side turns on only after the low side is off
    assert_gap_before_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_hi) && $past(dead) != '0) |-> $past(!gate_lo));

    assert_gap_before_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_lo) && $past(dead) != '0) |-> $past(!gate_hi));

endmodule

// File: rtl/fmpwm_gen.sv
module fmpwm_gen #(
    parameter int ACC_W = 16,
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic ser_data,
    input  logic ser_load,
    output logic gate_hi,
    output logic gate_lo
);
    localparam int DT_W = ACC_W - CNT_W;

    logic             wr_valid;
    logic             wr_addr;
    logic [ACC_W-1:0] wr_data;
    logic             pwm;
    logic             run;
    logic [DT_W-1:0]  dead;

    fmpwm_serial #(.DATA_W(ACC_W)) u_serial (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_clk  (ser_clk),
        .ser_data (ser_data),
        .ser_load (ser_load),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    fmpwm_core #(.ACC_W(ACC_W), .CNT_W(CNT_W), .DT_W(DT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .pwm      (pwm),
        .run      (run),
        .dead     (dead)
    );

    fmpwm_deadtime #(.DT_W(DT_W)) u_deadtime (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwm     (pwm),
        .run     (run),
        .dead    (dead),
        .gate_hi (gate_hi),
        .gate_lo (gate_lo)
    );

endmodule

// File: tb/tb_fmpwm_gen.sv
`timescale 1ns/1ps
module tb_fmpwm_gen;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_data = 1'b0;
    logic ser_load = 1'b0;
    logic gate_hi, gate_lo;

    always #2 clk = ~clk;

    fmpwm_gen dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_clk  (ser_clk),
        .ser_data (ser_data),
        .ser_load (ser_load),
        .gate_hi  (gate_hi),
        .gate_lo  (gate_lo)
    );

    typedef struct {
        int    kind;   // 0 gap, 1 high width, 2 low width
        int    val;
        string tag;
    } item_t;

    item_t sb_q[$];
    int    checks = 0;
    int    errors = 0;
    bit    armed = 0;
    bit    done = 0;
    int    cyc = 0;
    int    hi_w = 0, lo_w = 0, lo_fall_t = 0, overlap = 0;
    bit    hi_prev = 0, lo_prev = 0;

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic mreport(int kind, int v);
        if (armed && sb_q.size() > 0 && sb_q[0].kind == kind) begin
            chk(v == sb_q[0].val, sb_q[0].tag, v, sb_q[0].val);
            void'(sb_q.pop_front());
        end
    endtask

    // monitor: measures gaps and pulse widths, pops the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (gate_hi && gate_lo) overlap++;
            if (!gate_lo && lo_prev) begin
                mreport(2, lo_w);
                lo_fall_t = cyc;
            end
            lo_w = gate_lo ? lo_w + 1 : 0;
            if (gate_hi && !hi_prev) mreport(0, cyc - lo_fall_t);
            if (!gate_hi && hi_prev) mreport(1, hi_w);
            hi_w = gate_hi ? hi_w + 1 : 0;
            hi_prev = gate_hi;
            lo_prev = gate_lo;
        end
    end

    task automatic send_word(bit addr, bit [15:0] d, bit do_load);
        bit [16:0] w;
        w = {addr, d};
        for (int i = 16; i >= 0; i--) begin
            @(negedge clk); ser_data = w[i];
            repeat (2) @(negedge clk); ser_clk = 1'b1;
            repeat (2) @(negedge clk); ser_clk = 1'b0;
        end
        if (do_load) begin
            repeat (2) @(negedge clk); ser_load = 1'b1;
            repeat (2) @(negedge clk); ser_load = 1'b0;
        end
    endtask

    task automatic settle();
        repeat (800) @(negedge clk);
    endtask

    // driver side of the scoreboard
    task automatic expect_run(int gap, int hw, int lw, string tag);
        int t;
        sb_q.push_back('{0, gap, {tag, " gap"}});
        sb_q.push_back('{1, hw, {tag, " high width"}});
        sb_q.push_back('{2, lw, {tag, " low width"}});
        armed = 1;
        t = 0;
        while (sb_q.size() > 0 && t < 3000) begin
            @(negedge clk);
            t++;
        end
        if (sb_q.size() > 0) begin
            chk(0, {tag, " timeout"}, sb_q.size(), 0);
            sb_q.delete();
        end
        armed = 0;
    endtask

    task automatic check_level(int n, bit eh, bit el, string tag);
        int bad;
        bad = 0;
        repeat (n) begin
            @(negedge clk);
            if (gate_hi !== eh || gate_lo !== el) bad++;
        end
        chk(bad == 0, tag, bad, 0);
    endtask

    // R10: a load during a high pulse must not cut it; next pulse uses new duty
    task automatic boundary_test();
        int w;
        do @(negedge clk); while (gate_hi);
        do @(negedge clk); while (!gate_hi);
        w = 1;
        while (1) begin
            @(negedge clk);
            if (!gate_hi) break;
            w++;
            if (w == 40) ser_load = 1'b1;
            if (w == 42) ser_load = 1'b0;
        end
        chk(w == 128, "R10 pulse in progress kept", w, 128);
        do @(negedge clk); while (!gate_hi);
        w = 1;
        while (1) begin
            @(negedge clk);
            if (!gate_hi) break;
            w++;
        end
        chk(w == 64, "R10 new duty from next period", w, 64);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(0, "watchdog expired", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(gate_hi == 0 && gate_lo == 0, "R7 reset state both low", {gate_hi, gate_lo}, 0);

        // stopped: control word applies at once, then start at F=4096 (T=16)
        send_word(1'b1, {12'd0, 4'd8}, 1'b1);
        send_word(1'b0, 16'd4096, 1'b1);
        settle();
        expect_run(0, 128, 128, "R1 R2 R8 d=8 D=0 F=4096");

        send_word(1'b1, {12'd0, 4'd4}, 1'b0);
        boundary_test();

        send_word(1'b1, {12'd5, 4'd4}, 1'b1);
        settle();
        expect_run(5, 59, 187, "R5 R2 d=4 D=5");

        // shift only, no strobe
        send_word(1'b1, {12'd0, 4'd12}, 1'b0);
        settle();
        expect_run(5, 59, 187, "R9 no load keeps d=4 D=5");

        send_word(1'b0, 16'd8192, 1'b1);
        send_word(1'b1, {12'd2, 4'd8}, 1'b1);
        settle();
        expect_run(2, 62, 62, "R1 R8 F=8192 d=8 D=2");

        send_word(1'b1, {12'd3, 4'd15}, 1'b1);
        settle();
        check_level(600, 1'b1, 1'b0, "R4 full duty high side on");

        send_word(1'b1, {12'd3, 4'd0}, 1'b1);
        settle();
        check_level(600, 1'b0, 1'b1, "R3 zero duty low side on");

        send_word(1'b0, 16'd0, 1'b1);
        settle();
        check_level(300, 1'b0, 1'b0, "R7 zero tuning word both low");

        send_word(1'b1, {12'd0, 4'd6}, 1'b1);
        send_word(1'b0, 16'd4096, 1'b1);
        settle();
        expect_run(0, 96, 160, "R7 R2 immediate load d=6 F=4096");

        chk(overlap == 0, "R6 outputs never both high", overlap, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule